// File: doc/BRIEF.md
# Alias Training Controller for a Load Dependence Predictor

This controller runs a short training episode for a PC-indexed load dependence predictor. A store probes a small table of counters that is indexed by a hash of the address. When the counter it reads is non-zero, loads that may alias with the store are still in flight. The store then presents the counter's index and value on the trigger port. The controller saves both values and enters its training mode.

While training is active, the controller watches the load-commit port. Each committing load carries its PC and the counter index that its address hashed to. When that index equals the saved one, the controller writes "dependent" into the prediction table at the entry selected by the load's PC. It does this in the same cycle as the commit, and it counts the load off the saved total. Training ends once the saved number of aliasing loads has committed. At that point the controller is free to accept another trigger. A trigger that arrives while training is active is dropped, and the controller flags it on a busy output.

Top module: `alias_train_ctrl`

## Requirements
- R1: After reset, `active`, `busy` and `upd_valid` are all 0.
- R2: When idle, a trigger with a non-zero `trig_cnt` starts training. `active` reads 1 from the next cycle on, and `trig_idx` and `trig_cnt` are saved.
- R3: While active, a commit whose `cmt_idx` equals the saved index drives `upd_valid`=1 and `upd_dep`=1 in the same cycle. `upd_addr` equals `cmt_pc[PT_W-1:0] ^ cmt_pc[2*PT_W-1:PT_W]`.
- R4: While active, a commit whose `cmt_idx` differs from the saved index produces no table write.
- R5: While idle, no commit produces a table write. This includes a commit in the same cycle as the starting trigger.
- R6: Training stays active until exactly the saved number of matching commits has happened. `active` falls at the clock edge that ends the cycle of the last matching commit.
- R7: A trigger that arrives while active leaves the saved index and count unchanged, and it raises `busy` in the same cycle.
- R8: A trigger with `trig_cnt`=0 does not start training and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Store probe hit reported |
| trig_idx | input | IDX_W | Counter index seen by the store |
| trig_cnt | input | CNT_W | Counter value seen by the store |
| cmt_valid | input | 1 | A load commits this cycle |
| cmt_pc | input | 2*PT_W | Low PC bits of the committing load |
| cmt_idx | input | IDX_W | Counter index saved with the load |
| active | output | 1 | Training mode is on |
| busy | output | 1 | Trigger dropped because training is on |
| upd_valid | output | 1 | Prediction table write strobe |
| upd_addr | output | PT_W | Prediction table entry to write |
| upd_dep | output | 1 | Value written: 1 means dependent |

## Verification
The bench sweeps every saved index against every legal non-zero count.

Each episode mixes three kinds of commit:
- Matching commits count down the episode and must each produce a write at the folded PC address.
- A non-matching commit must not write anything.
- A matching commit in the same cycle as the starting trigger must not write anything.

A second trigger, with a different index and the largest count, arrives during each episode. If it were accepted, later matches would fail and the exit cycle would move, so the bench can tell an ignored trigger from an accepted one. Zero-count triggers check that no training starts.

// File: rtl/alias_train_ctrl.sv
module alias_train_ctrl #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 2,
  parameter int PT_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [IDX_W-1:0]   trig_idx,
  input  logic [CNT_W-1:0]   trig_cnt,
  input  logic               cmt_valid,
  input  logic [2*PT_W-1:0]  cmt_pc,
  input  logic [IDX_W-1:0]   cmt_idx,
  output logic               active,
  output logic               busy,
  output logic               upd_valid,
  output logic [PT_W-1:0]    upd_addr,
  output logic               upd_dep
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             on_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] left_q;

  wire start = !on_q && trig_valid && (trig_cnt != '0);
  wire hit   = on_q && cmt_valid && (cmt_idx == idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      on_q   <= 1'b1;
      idx_q  <= trig_idx;
      left_q <= trig_cnt;
    end else if (hit) begin
      left_q <= left_q - ONE;
      if (left_q == ONE) on_q <= 1'b0;
    end
  end

  assign active    = on_q;
  assign busy      = on_q && trig_valid;
  assign upd_valid = hit;
  assign upd_addr  = cmt_pc[PT_W-1:0] ^ cmt_pc[2*PT_W-1:PT_W];
  assign upd_dep   = 1'b1;
endmodule

// File: rtl/alias_train_chk.sv
module alias_train_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_valid,
  input logic [CNT_W-1:0] trig_cnt,
  input logic             cmt_valid,
  input logic             active,
  input logic             busy,
  input logic             upd_valid,
  input logic             upd_dep
);
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && trig_valid && trig_cnt != '0) |=> active);

  a_r5_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !upd_valid);

  a_r3_write_shape: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (cmt_valid && upd_dep));

  a_r6_exit_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !upd_valid) |=> active);

  a_r7_busy_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (active && trig_valid));

  a_r8_zero_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && trig_valid && trig_cnt == '0) |=> !active);
endmodule

bind alias_train_ctrl alias_train_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_cnt(trig_cnt),
  .cmt_valid(cmt_valid), .active(active), .busy(busy),
  .upd_valid(upd_valid), .upd_dep(upd_dep)
);

// File: tb/alias_train_ctrl_tb.sv
module alias_train_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int CNT_W = 2;
  localparam int PT_W  = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic trig_valid = 0;
  logic [IDX_W-1:0] trig_idx = '0;
  logic [CNT_W-1:0] trig_cnt = '0;
  logic cmt_valid = 0;
  logic [2*PT_W-1:0] cmt_pc = '0;
  logic [IDX_W-1:0] cmt_idx = '0;
  logic active, busy, upd_valid, upd_dep;
  logic [PT_W-1:0] upd_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_train_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W), .PT_W(PT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_idx(trig_idx),
    .trig_cnt(trig_cnt), .cmt_valid(cmt_valid), .cmt_pc(cmt_pc), .cmt_idx(cmt_idx),
    .active(active), .busy(busy), .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_dep(upd_dep));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit tv, int ti, int tc, bit cv, int pc, int ci);
    @(negedge clk);
    trig_valid = tv; trig_idx = IDX_W'(ti); trig_cnt = CNT_W'(tc);
    cmt_valid = cv; cmt_pc = (2*PT_W)'(pc); cmt_idx = IDX_W'(ci);
    #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    drive(0, 0, 0, 0, 0, 0);
    check("R1 active", active, 0);
    check("R1 busy", busy, 0);
    check("R1 upd_valid", upd_valid, 0);
    rst_n = 1;
    for (int cnt = 1; cnt < (1 << CNT_W); cnt++) begin
      for (int idx = 0; idx < (1 << IDX_W); idx++) begin
        int other;
        other = idx ^ 1;
        drive(1, idx, cnt, 1, 12'h5A5, idx);
        check("R5 write on start cycle", upd_valid, 0);
        check("R8 busy on idle trigger", busy, 0);
        drive(0, 0, 0, 0, 0, 0);
        check("R2 active after trigger", active, 1);
        drive(1, other, (1 << CNT_W) - 1, 0, 0, 0);
        check("R7 busy", busy, 1);
        for (int k = 0; k < cnt; k++) begin
          int pc;
          pc = (idx * 97 + k * 331 + cnt * 53) & ((1 << (2*PT_W)) - 1);
          drive(0, 0, 0, 1, pc, other);
          check("R4 no write on mismatch", upd_valid, 0);
          check("R6 still active", active, 1);
          drive(0, 0, 0, 1, pc, idx);
          check("R3 upd_valid", upd_valid, 1);
          check("R3 upd_dep", upd_dep, 1);
          check("R3 upd_addr", upd_addr,
                (pc & ((1 << PT_W) - 1)) ^ (pc >> PT_W));
        end
        drive(0, 0, 0, 1, 0, idx);
        check("R6 exited after count", active, 0);
        check("R5 no write when idle", upd_valid, 0);
        drive(1, idx, 0, 0, 0, 0);
        check("R8 busy on zero trigger", busy, 0);
        drive(0, 0, 0, 1, 0, idx);
        check("R8 no entry on zero count", active, 0);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule